// File: doc/BRIEF.md
# RAS/CAS Refresh Cycle Decoder

This block sits on the device side of a video DRAM random-access port and interprets its row and column strobes. Inputs are sampled on a system clock. When the row strobe is first seen low, the block looks at the column strobe, the special-function input and the write-bit/write-enable input. It then classifies the cycle. A row strobe with the column strobe high is a RAS-only cycle that uses the external row address. A column strobe that was already low for the setup window makes a CAS-before-RAS refresh, and that refresh has three variants. A column strobe that went low too recently for the setup window is reported as a normal access.

For each CAS-before-RAS refresh, the row comes from an internal refresh counter, which then steps. One variant clears the option state: it drops the persistent write-mask mode and sets the stop register back to its default. Another only refreshes. The third loads the stop register from the address pins. Read data captured in an access stays on the output through a hidden refresh, which is a CAS-before-RAS cycle issued while the column strobe stays low after a read.

All pins are plain level controls. The port carries no data stream, so no valid/ready handshake applies: the array data input is sampled at the column strobe falling edge of a read, and the cycle-type code is a single-clock pulse that the consumer cannot stall.

Top module: `cbr_refresh_decoder`

## Requirements
- R1: When the row strobe falls with the column strobe high, the cycle type reads 2 (RAS-only) and the row output equals the address pins sampled at that fall. The refresh counter does not move.
- R2: The cycle counts as CAS-before-RAS only if the column strobe has been low at CSR_CYC or more earlier clock edges when the row strobe fall is seen. If the column strobe is low for fewer edges, the cycle type reads 1 (normal access) and the external address is used.
- R3: In every CAS-before-RAS cycle the row output is the refresh counter value, and the counter then increments. It is 0 after reset and wraps from 511 to 0.
- R4: A CAS-before-RAS cycle with the special-function input low reads type 3. It restores the stop register to STOP_DEF and clears the persistent write-mask flag.
- R5: A CAS-before-RAS cycle with the special-function input high and write-bit/write-enable high reads type 4. It leaves the stop register and the write-mask flag unchanged.
- R6: A CAS-before-RAS cycle with the special-function input high and write-bit/write-enable low reads type 5. It loads the stop register from the address pins.
- R7: The cycle type shows its code during the one clock after the edge where the row strobe fall is seen. At all other times it reads 0.
- R8: A RAS-only or normal cycle that has write-bit/write-enable low at the row strobe fall sets the persistent write-mask flag.
- R9: In a RAS-only or normal cycle, a column strobe fall with write-bit/write-enable high captures the array data onto the data output.
- R10: The captured data and its output enable stay unchanged through a hidden refresh, for as long as the column strobe stays low.
- R11: The data output enable is low whenever the output-enable pin is high. It is also low from the clock after the column strobe is seen high.
- R12: After reset: type 0, row 0, stop register STOP_DEF, write-mask flag 0, data output enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| dsf | input | 1 | Special-function select, sampled at row strobe fall |
| wbwe_n | input | 1 | Write-bit/write-enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_i | input | AW | Multiplexed address pins |
| arr_rdata_i | input | DW | Data read from the array |
| cyc_type_o | output | 3 | Cycle code pulse: 0 none, 1 normal, 2 RAS-only, 3 refresh+reset, 4 refresh, 5 refresh+stop load |
| row_addr_o | output | AW | Row to activate, valid with the cycle code |
| stop_o | output | AW | Stop register |
| mask_keep_o | output | 1 | Persistent write-mask mode flag |
| dq_o | output | DW | Held read data |
| dq_oe_o | output | 1 | Data output driver enable |

## Verification
Some properties are checked by assertions on every clock. The cycle code is a one-clock pulse. A refresh code always follows a low column strobe. RAS-only rows match the sampled address. The counter moves only on a refresh. The plain refresh leaves the option registers alone, and the reset variant restores them. Held data cannot change during a refresh, and the driver is released once the column strobe is high.

Other behaviour only the bench scenarios can show. These are the exact setup-window boundary between a normal access and a refresh, and the counter wrap after 512 refreshes. They also include the stop value loaded from the pins, and a full hidden refresh that follows a read and keeps the read value on the output.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic [2:0] {
    CY_NONE      = 3'd0,
    CY_NORMAL    = 3'd1,
    CY_RONLY     = 3'd2,
    CY_CBR_RST   = 3'd3,
    CY_CBR_PLAIN = 3'd4,
    CY_CBR_SET   = 3'd5
  } cyc_e;

  function automatic logic is_cbr(cyc_e k);
    return (k == CY_CBR_RST) || (k == CY_CBR_PLAIN) || (k == CY_CBR_SET);
  endfunction
endpackage

// File: rtl/rcd_strobe_track.sv
module rcd_strobe_track #(
  parameter int CSR_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall,
  output logic cbr_ok
);
  localparam int CW = $clog2(CSR_CYC + 1);

  logic          ras_prev, cas_prev;
  logic [CW-1:0] cas_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev <= 1'b1;
      cas_prev <= 1'b1;
      cas_cnt  <= '0;
    end else begin
      ras_prev <= ras_n;
      cas_prev <= cas_n;
      if (cas_n)
        cas_cnt <= '0;
      else if (cas_cnt != CW'(CSR_CYC))
        cas_cnt <= cas_cnt + 1'b1;
    end
  end

  assign ras_fall = ras_prev & ~ras_n;
  assign ras_rise = ~ras_prev & ras_n;
  assign cas_fall = cas_prev & ~cas_n;
  assign cbr_ok   = ~cas_n && (cas_cnt >= CW'(CSR_CYC));

  // R2
  cbr_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_ok |-> $past(!cas_n));
endmodule

// File: rtl/rcd_classify.sv
module rcd_classify
  import rcd_pkg::*;
(
  input  logic ras_fall,
  input  logic cas_n,
  input  logic cbr_ok,
  input  logic dsf,
  input  logic wbwe_n,
  output cyc_e kind
);
  always_comb begin
    kind = CY_NONE;
    if (ras_fall) begin
      if (cbr_ok) begin
        if (!dsf)        kind = CY_CBR_RST;
        else if (wbwe_n) kind = CY_CBR_PLAIN;
        else             kind = CY_CBR_SET;
      end else if (!cas_n) begin
        kind = CY_NORMAL;
      end else begin
        kind = CY_RONLY;
      end
    end
  end
endmodule

// File: rtl/rcd_refcnt.sv
module rcd_refcnt #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] cnt_o
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
endmodule

// File: rtl/rcd_optregs.sv
module rcd_optregs
  import rcd_pkg::*;
#(
  parameter int          AW       = 9,
  parameter logic [AW-1:0] STOP_DEF = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          kind,
  input  logic          wbwe_n,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] stop_o,
  output logic          mask_keep_o
);
  logic [AW-1:0] stop_q;
  logic          mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= STOP_DEF;
      mask_q <= 1'b0;
    end else begin
      unique case (kind)
        CY_CBR_RST: begin
          stop_q <= STOP_DEF;
          mask_q <= 1'b0;
        end
        CY_CBR_SET: stop_q <= addr_i;
        CY_NORMAL, CY_RONLY: if (!wbwe_n) mask_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign stop_o      = stop_q;
  assign mask_keep_o = mask_q;

  // R5
  plain_keeps_opts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CY_CBR_PLAIN) |=> ($stable(stop_q) && $stable(mask_q)));
  // R4
  reset_variant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CY_CBR_RST) |=> (stop_q == STOP_DEF && !mask_q));
endmodule

// File: rtl/rcd_readhold.sv
module rcd_readhold
  import rcd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          kind,
  input  logic          ras_rise,
  input  logic          cas_fall,
  input  logic          cas_n,
  input  logic          wbwe_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_rdata_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic          acc_q, valid_q;
  logic [DW-1:0] dq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      valid_q <= 1'b0;
      dq_q    <= '0;
    end else begin
      if (kind == CY_NORMAL || kind == CY_RONLY) acc_q <= 1'b1;
      else if (ras_rise || is_cbr(kind))         acc_q <= 1'b0;

      if (cas_n) begin
        valid_q <= 1'b0;
      end else if (cas_fall && acc_q && wbwe_n) begin
        valid_q <= 1'b1;
        dq_q    <= arr_rdata_i;
      end
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = valid_q & ~oe_n;

  // R10
  hidden_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cbr(kind) && valid_q) |=> ($stable(dq_q) && valid_q));
  // R11
  cas_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !valid_q);
endmodule

// File: rtl/cbr_refresh_decoder.sv
module cbr_refresh_decoder
  import rcd_pkg::*;
#(
  parameter int            AW       = 9,
  parameter int            DW       = 16,
  parameter int            CSR_CYC  = 2,
  parameter logic [AW-1:0] STOP_DEF = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          dsf,
  input  logic          wbwe_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] arr_rdata_i,
  output logic [2:0]    cyc_type_o,
  output logic [AW-1:0] row_addr_o,
  output logic [AW-1:0] stop_o,
  output logic          mask_keep_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic          ras_fall, ras_rise, cas_fall, cbr_ok;
  cyc_e          kind;
  logic [AW-1:0] ref_cnt;
  cyc_e          cyc_q;
  logic [AW-1:0] row_q;

  rcd_strobe_track #(.CSR_CYC(CSR_CYC)) u_trk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall), .cbr_ok(cbr_ok)
  );

  rcd_classify u_cls (
    .ras_fall(ras_fall), .cas_n(cas_n), .cbr_ok(cbr_ok),
    .dsf(dsf), .wbwe_n(wbwe_n), .kind(kind)
  );

  rcd_refcnt #(.AW(AW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(is_cbr(kind)), .cnt_o(ref_cnt)
  );

  rcd_optregs #(.AW(AW), .STOP_DEF(STOP_DEF)) u_opt (
    .clk(clk), .rst_n(rst_n), .kind(kind), .wbwe_n(wbwe_n), .addr_i(addr_i),
    .stop_o(stop_o), .mask_keep_o(mask_keep_o)
  );

  rcd_readhold #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .kind(kind), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_n(cas_n), .wbwe_n(wbwe_n), .oe_n(oe_n),
    .arr_rdata_i(arr_rdata_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= CY_NONE;
      row_q <= '0;
    end else begin
      cyc_q <= kind;
      if (kind != CY_NONE) row_q <= is_cbr(kind) ? ref_cnt : addr_i;
    end
  end

  assign cyc_type_o = cyc_q;
  assign row_addr_o = row_q;

  // R7
  one_clock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != CY_NONE) |=> (cyc_q == CY_NONE));
  // R7
  code_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != CY_NONE) |-> $past(!ras_n));
  // R1
  ronly_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == CY_RONLY) |-> (row_q == $past(addr_i) && $past(cas_n)));
  // R2
  cbr_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cbr(cyc_q) |-> $past(!cas_n));
endmodule

// File: tb/sim_cbr_refresh_decoder.sv
module sim_cbr_refresh_decoder;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW = 9;
  localparam int          DW = 16;
  localparam int          CSR = 2;
  localparam logic [8:0]  SDEF = 9'h1FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, dsf = 1'b0, wbwe_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] arr_rdata_i = '0;
  logic [2:0]    cyc_type_o;
  logic [AW-1:0] row_addr_o, stop_o;
  logic          mask_keep_o, dq_oe_o;
  logic [DW-1:0] dq_o;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_cnt = '0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_refresh_decoder #(.AW(AW), .DW(DW), .CSR_CYC(CSR), .STOP_DEF(SDEF)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dsf(dsf),
    .wbwe_n(wbwe_n), .oe_n(oe_n), .addr_i(addr_i), .arr_rdata_i(arr_rdata_i),
    .cyc_type_o(cyc_type_o), .row_addr_o(row_addr_o), .stop_o(stop_o),
    .mask_keep_o(mask_keep_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // CBR cycle; returns type and row at the sampling point, then idles the strobes
  task automatic cbr(input logic d, input logic w, input logic [AW-1:0] a,
                     output logic [2:0] ty, output logic [AW-1:0] row);
    @(negedge clk); cas_n = 1'b0;
    repeat (CSR) @(negedge clk);
    ras_n = 1'b0; dsf = d; wbwe_n = w; addr_i = a;
    @(negedge clk); ty = cyc_type_o; row = row_addr_o;
    ras_n = 1'b1; cas_n = 1'b1; dsf = 1'b0; wbwe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 type", 32'(cyc_type_o), 0);
    check("R12 row", 32'(row_addr_o), 0);
    check("R12 stop", 32'(stop_o), 32'(SDEF));
    check("R12 mask", 32'(mask_keep_o), 0);
    check("R12 dq_oe", 32'(dq_oe_o), 0);
  endtask

  task automatic t_ras_only();
    @(negedge clk); ras_n = 1'b0; addr_i = 9'h0A5; wbwe_n = 1'b1;
    @(negedge clk);
    check("R1 type", 32'(cyc_type_o), 2);
    check("R1 row", 32'(row_addr_o), 32'h0A5);
    ras_n = 1'b1; addr_i = 9'h000;
    @(negedge clk);
    check("R7 back to none", 32'(cyc_type_o), 0);
    check("R8 mask untouched on read", 32'(mask_keep_o), 0);
  endtask

  task automatic t_setup_window();
    logic [2:0] ty; logic [AW-1:0] row;
    @(negedge clk); cas_n = 1'b0;
    repeat (CSR-1) @(negedge clk);
    ras_n = 1'b0; addr_i = 9'h13C; dsf = 1'b1;
    @(negedge clk);
    check("R2 short setup is normal", 32'(cyc_type_o), 1);
    check("R2 external row", 32'(row_addr_o), 32'h13C);
    ras_n = 1'b1; cas_n = 1'b1; dsf = 1'b0;
    @(negedge clk);
    cbr(1'b1, 1'b1, 9'h055, ty, row);
    check("R2 full setup is CBR", 32'(ty), 4);
    check("R3 counter unaffected by earlier cycles", 32'(row), 32'(exp_cnt));
    exp_cnt++;
  endtask

  task automatic t_options();
    logic [2:0] ty; logic [AW-1:0] row;
    @(negedge clk); ras_n = 1'b0; wbwe_n = 1'b0; addr_i = 9'h010;
    @(negedge clk);
    check("R8 mask armed", 32'(mask_keep_o), 1);
    ras_n = 1'b1; wbwe_n = 1'b1;
    @(negedge clk);
    cbr(1'b1, 1'b0, 9'h033, ty, row);
    check("R6 type", 32'(ty), 5);
    check("R6 stop loaded", 32'(stop_o), 32'h033);
    check("R6 row from counter", 32'(row), 32'(exp_cnt));
    exp_cnt++;
    cbr(1'b1, 1'b1, 9'h1AA, ty, row);
    check("R5 type", 32'(ty), 4);
    check("R5 stop kept", 32'(stop_o), 32'h033);
    check("R5 mask kept", 32'(mask_keep_o), 1);
    exp_cnt++;
    cbr(1'b0, 1'b1, 9'h0F0, ty, row);
    check("R4 type", 32'(ty), 3);
    check("R4 stop default", 32'(stop_o), 32'(SDEF));
    check("R4 mask cleared", 32'(mask_keep_o), 0);
    check("R4 row from counter", 32'(row), 32'(exp_cnt));
    exp_cnt++;
  endtask

  task automatic t_hidden();
    @(negedge clk); ras_n = 1'b0; addr_i = 9'h077; wbwe_n = 1'b1;
    @(negedge clk); cas_n = 1'b0; arr_rdata_i = 16'hBEEF;
    @(negedge clk);
    check("R9 data captured", 32'(dq_o), 32'hBEEF);
    check("R9 driver on", 32'(dq_oe_o), 1);
    ras_n = 1'b1; arr_rdata_i = 16'h1234;
    @(negedge clk); ras_n = 1'b0; dsf = 1'b1; wbwe_n = 1'b1;
    @(negedge clk);
    check("R10 hidden is CBR", 32'(cyc_type_o), 4);
    check("R10 hidden row", 32'(row_addr_o), 32'(exp_cnt));
    check("R10 data held", 32'(dq_o), 32'hBEEF);
    check("R10 driver held", 32'(dq_oe_o), 1);
    exp_cnt++;
    oe_n = 1'b1; #1;
    check("R11 oe high releases", 32'(dq_oe_o), 0);
    oe_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; dsf = 1'b0;
    @(negedge clk);
    check("R11 cas high releases", 32'(dq_oe_o), 0);
  endtask

  task automatic t_wrap();
    logic [2:0] ty; logic [AW-1:0] row;
    int errs = 0;
    for (int i = 0; i < 520; i++) begin
      cbr(1'b1, 1'b1, 9'h000, ty, row);
      if (row !== exp_cnt) errs++;
      check("R3 counter sequence", 32'(row), 32'(exp_cnt));
      exp_cnt++;
    end
    check("R3 wrap no errors", 32'(errs), 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
          summary();
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ras_only();
    t_setup_window();
    t_options();
    t_hidden();
    t_wrap();
    done = 1'b1;
    summary();
  end
endmodule